// File: doc/BRIEF.md
# PPS-Aligned Sample Timing Generator

This block derives a sample-set strobe from a disciplined reference clock by integer division: at the defaults, an 8 MHz clock divided by 1000 gives one strobe every 125 µs, or 8000 sets per second. A one-pulse-per-second input arrives from a separate timing source and is not phase-locked to the clock. The block passes it through a two-flop synchroniser and detects its rising edge. Each accepted edge hard-restarts the divider and the per-second sample index, so every second of sampling starts on the timing pulse.

For every strobe the block issues a staggered capture request to three converter channels and presents the index of the set within the current second. Each set carries three 16-bit samples, which is 48000 bytes per second at the nominal rate. The block counts seconds. On each pulse edge it checks the number of sets seen in the second that has just ended and latches that index. If the pulse stops arriving, the divider keeps running on its own and a status bit is set.

Top module: `pps_timing_gen`

## Requirements
- R1: After reset, every output is 0, and no strobe or capture request is issued until the first rising edge of `pps_i`.
- R2: When `pps_i` rises and then stays high, `strobe_o` goes high on the third rising clock edge after the rise, with `sample_idx_o` = 0. This holds at any divider phase.
- R3: Between pulse edges, strobes are exactly CLK_DIV clock cycles apart. Each strobe is one cycle wide, and `sample_idx_o` advances by 1 at each strobe.
- R4: Bit c of `capture_req_o` is high for exactly one cycle, c cycles after each strobe. Bit 0 is high in the strobe cycle, and at most one bit is high at a time.
- R5: `seconds_o` increments by 1 on each rising edge of `pps_i`. A pulse that is held high counts only once.
- R6: On every pulse edge after the first, `count_err_o` becomes 1 if `sample_idx_o` was not SETS_PER_SEC-1 at that edge, and 0 if it was. `count_seen_o` latches that index.
- R7: If a strobe falls due while `sample_idx_o` = SETS_PER_SEC+MISS_MARGIN-1 and no pulse edge has arrived, the index wraps to 0 and `pps_missing_o` is set. The next pulse edge clears the bit.
- R8: The index never exceeds SETS_PER_SEC+MISS_MARGIN-1. The first pulse edge after reset updates neither `count_err_o` nor `count_seen_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pps_i | input | 1 | Asynchronous one-pulse-per-second input |
| strobe_o | output | 1 | One-cycle sample-set strobe |
| sample_idx_o | output | IDX_W | Index of the current set within the second |
| capture_req_o | output | NUM_CH | Staggered per-channel capture requests |
| seconds_o | output | SEC_W | Count of accepted pulse edges |
| count_err_o | output | 1 | Last completed second did not end on the nominal index |
| count_seen_o | output | IDX_W | Index latched at the last pulse edge |
| pps_missing_o | output | 1 | The divider wrapped without a pulse |

## Verification
The assertions assume the following about the inputs. The divider ratio is larger than the channel count, so request trains never overlap. The pulse is either low or stays high for at least three clock cycles, so the synchroniser never produces a pulse edge on two cycles in a row. The stimulus raises the pulse just after a strobe, holds it for several cycles and releases it well before the next rise. The bench uses reduced divider and per-second counts so that nominal, short, long and missing seconds all fit in a short run. The pulse is driven on the falling clock edge, which fixes the three-edge latency that the checks expect.

// File: rtl/pps_timing_pkg.sv
package pps_timing_pkg;
  localparam int unsigned DEF_CLK_DIV      = 1000;
  localparam int unsigned DEF_SETS_PER_SEC = 8000;
  localparam int unsigned DEF_MISS_MARGIN  = 4;
  localparam int unsigned DEF_NUM_CH       = 3;
  localparam int unsigned DEF_SEC_W        = 32;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pps_i,
  output logic edge_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pps_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign edge_o = sync_q & ~prev_q;

  // held pulse yields a single edge
  p_edge_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/set_divider.sv
module set_divider #(
  parameter int unsigned CLK_DIV      = 1000,
  parameter int unsigned SETS_PER_SEC = 8000,
  parameter int unsigned MISS_MARGIN  = 4,
  parameter int unsigned IDX_W        = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pps_edge_i,
  output logic             armed_o,
  output logic             strobe_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             missing_o
);
  localparam int unsigned DIV_W = pps_timing_pkg::cnt_width(CLK_DIV);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [IDX_W-1:0] IDX_WRAP = IDX_W'(SETS_PER_SEC + MISS_MARGIN - 1);

  logic [DIV_W-1:0] div_q;
  logic             armed_q, strobe_q, missing_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      div_q     <= '0;
      idx_q     <= '0;
      strobe_q  <= 1'b0;
      missing_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (pps_edge_i) begin
        armed_q   <= 1'b1;
        div_q     <= '0;
        idx_q     <= '0;
        strobe_q  <= 1'b1;
        missing_q <= 1'b0;
      end else if (armed_q) begin
        if (div_q == DIV_LAST) begin
          div_q    <= '0;
          strobe_q <= 1'b1;
          if (idx_q == IDX_WRAP) begin
            idx_q     <= '0;
            missing_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign armed_o   = armed_q;
  assign strobe_o  = strobe_q;
  assign idx_o     = idx_q;
  assign missing_o = missing_q;

  p_restart_idx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pps_edge_i |=> (strobe_o && idx_o == '0));
  p_no_strobe_unarmed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_o |-> !strobe_o);
  p_strobe_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && !pps_edge_i) |=> !strobe_o);
  p_idx_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_o <= IDX_WRAP);
  p_missing_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pps_edge_i |=> !missing_o);
endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  output logic [NUM_CH-1:0] req_o
);
  assign req_o[0] = strobe_i;

  for (genvar c = 1; c < NUM_CH; c++) begin : g_stage
    logic stage_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= 1'b0;
      else         stage_q <= req_o[c-1];
    end
    assign req_o[c] = stage_q;
  end

  // relies on strobes spaced wider than the channel count
  p_req_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_o));
endmodule

// File: rtl/pps_timing_gen.sv
module pps_timing_gen #(
  parameter int unsigned CLK_DIV      = pps_timing_pkg::DEF_CLK_DIV,
  parameter int unsigned SETS_PER_SEC = pps_timing_pkg::DEF_SETS_PER_SEC,
  parameter int unsigned MISS_MARGIN  = pps_timing_pkg::DEF_MISS_MARGIN,
  parameter int unsigned NUM_CH       = pps_timing_pkg::DEF_NUM_CH,
  parameter int unsigned SEC_W        = pps_timing_pkg::DEF_SEC_W,
  localparam int unsigned IDX_W = pps_timing_pkg::cnt_width(SETS_PER_SEC + MISS_MARGIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pps_i,
  output logic              strobe_o,
  output logic [IDX_W-1:0]  sample_idx_o,
  output logic [NUM_CH-1:0] capture_req_o,
  output logic [SEC_W-1:0]  seconds_o,
  output logic              count_err_o,
  output logic [IDX_W-1:0]  count_seen_o,
  output logic              pps_missing_o
);
  localparam logic [IDX_W-1:0] IDX_NOM = IDX_W'(SETS_PER_SEC - 1);

  logic pps_edge, armed, strobe;
  logic [IDX_W-1:0] idx;
  logic [SEC_W-1:0] secs_q;
  logic             err_q;
  logic [IDX_W-1:0] seen_q;

  pps_edge_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pps_i  (pps_i),
    .edge_o (pps_edge)
  );

  set_divider #(
    .CLK_DIV      (CLK_DIV),
    .SETS_PER_SEC (SETS_PER_SEC),
    .MISS_MARGIN  (MISS_MARGIN),
    .IDX_W        (IDX_W)
  ) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pps_edge_i (pps_edge),
    .armed_o    (armed),
    .strobe_o   (strobe),
    .idx_o      (idx),
    .missing_o  (pps_missing_o)
  );

  capture_sequencer #(.NUM_CH(NUM_CH)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe),
    .req_o    (capture_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      secs_q <= '0;
      err_q  <= 1'b0;
      seen_q <= '0;
    end else if (pps_edge) begin
      secs_q <= secs_q + 1'b1;
      if (armed) begin
        err_q  <= (idx != IDX_NOM);
        seen_q <= idx;
      end
    end
  end

  assign strobe_o     = strobe;
  assign sample_idx_o = idx;
  assign seconds_o    = secs_q;
  assign count_err_o  = err_q;
  assign count_seen_o = seen_q;

  p_secs_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pps_edge |=> seconds_o == $past(seconds_o) + 1'b1);
  p_secs_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pps_edge |=> $stable(seconds_o));
  p_seen_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pps_edge |=> ($stable(count_seen_o) && $stable(count_err_o)));
endmodule

// File: tb/pps_timing_gen_bench.sv
module pps_timing_gen_bench;
  localparam int DIV = 10, SETS = 20, MARGIN = 4, NCH = 3;
  localparam int IW = pps_timing_pkg::cnt_width(SETS + MARGIN);

  logic clk = 1'b0, rst_n = 1'b0, pps = 1'b0;
  logic strobe, cerr, miss;
  logic [IW-1:0] idx, seen;
  logic [NCH-1:0] req;
  logic [31:0] secs;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pps_timing_gen #(.CLK_DIV(DIV), .SETS_PER_SEC(SETS), .MISS_MARGIN(MARGIN),
                   .NUM_CH(NCH), .SEC_W(32)) u_pps_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .pps_i(pps), .strobe_o(strobe),
    .sample_idx_o(idx), .capture_req_o(req), .seconds_o(secs),
    .count_err_o(cerr), .count_seen_o(seen), .pps_missing_o(miss));

  task automatic check(input string r, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic next_strobe(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!strobe && gap < 1000);
  endtask

  task automatic pps_rise(output int lat);
    pps = 1'b1; lat = 0;
    do begin @(negedge clk); lat++; end while (!strobe && lat < 1000);
  endtask

  task automatic pps_fall();
    repeat (2) @(negedge clk);
    pps = 1'b0;
  endtask

  task automatic advance_to(input int k);
    int g, n = 0;
    do begin next_strobe(g); n++; end while (idx != IW'(k) && n < 100);
  endtask

  task automatic t_reset();
    int seen_strobes = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 strobe", strobe, 0); check("R1 idx", idx, 0);
    check("R1 secs", secs, 0); check("R1 err", cerr, 0);
    check("R1 missing", miss, 0); check("R1 seen", seen, 0);
    repeat (40) begin @(negedge clk); if (strobe || req != 0) seen_strobes++; end
    check("R1 no strobe before pps", seen_strobes, 0);
  endtask

  task automatic t_first_pps();
    int lat, g;
    pps_rise(lat);
    check("R2 latency", lat, 3); check("R2 idx", idx, 0);
    check("R5 secs first", secs, 1);
    check("R8 err first", cerr, 0); check("R8 seen first", seen, 0);
    check("R4 req ch0", req, 3'b001);
    @(negedge clk); check("R4 req ch1", req, 3'b010); check("R3 width", strobe, 0);
    @(negedge clk); check("R4 req ch2", req, 3'b100);
    @(negedge clk); check("R4 req idle", req, 3'b000);
    pps = 1'b0;
    next_strobe(g); check("R3 idx step", idx, 1);
    next_strobe(g); check("R3 period", g, DIV); check("R3 idx step2", idx, 2);
  endtask

  task automatic t_nominal(input int exp_secs);
    int lat;
    advance_to(SETS - 1);
    pps_rise(lat);
    check("R2 latency nominal", lat, 3); check("R2 idx nominal", idx, 0);
    check("R6 err nominal", cerr, 0); check("R6 seen nominal", seen, SETS - 1);
    check("R5 secs nominal", secs, exp_secs);
    repeat (25) @(negedge clk);
    check("R5 held pulse", secs, exp_secs);
    pps = 1'b0;
  endtask

  task automatic t_short();
    int lat;
    advance_to(9);
    pps_rise(lat);
    check("R2 latency short", lat, 3);
    check("R6 err short", cerr, 1); check("R6 seen short", seen, 9);
    pps_fall();
  endtask

  task automatic t_long();
    int lat;
    advance_to(SETS + 2);
    check("R7 no missing in margin", miss, 0);
    pps_rise(lat);
    check("R6 err long", cerr, 1); check("R6 seen long", seen, SETS + 2);
    check("R7 missing long", miss, 0);
    pps_fall();
  endtask

  task automatic t_missing(input int exp_secs);
    int lat, g;
    advance_to(SETS + MARGIN - 1);
    check("R7 missing before wrap", miss, 0);
    next_strobe(g);
    check("R7 wrap gap", g, DIV); check("R7 wrap idx", idx, 0);
    check("R7 missing set", miss, 1);
    advance_to(5);
    check("R7 missing held", miss, 1);
    pps_rise(lat);
    check("R7 missing cleared", miss, 0);
    check("R6 err after miss", cerr, 1); check("R6 seen after miss", seen, 5);
    check("R5 secs after miss", secs, exp_secs);
    pps_fall();
  endtask

  task automatic t_reset_mid();
    int cnt = 0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 secs mid reset", secs, 0); check("R1 err mid reset", cerr, 0);
    rst_n = 1'b1;
    repeat (30) begin @(negedge clk); if (strobe) cnt++; end
    check("R1 no strobe after mid reset", cnt, 0);
    check("R1 idx mid reset", idx, 0);
  endtask

  initial begin
    t_reset();
    t_first_pps();
    t_nominal(2);
    t_short();
    t_long();
    t_missing(5);
    t_nominal(6);
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule